// File: doc/BRIEF.md
# Command Queue Register Front End

This block sits between a register bus and a circular queue of 32-byte commands that software places in memory. Software programs where the queue lives and how many 4 KiB pages it spans, then publishes new work by moving a write offset forward. The block fetches the commands one at a time through a simple memory read port. It hands each fetched command to a downstream executor, and moves its own read offset forward once that command is finished.

A control register carries an enable bit, which locks the queue base register, and an idle flag that shows whether any published work is still pending. Each register is 64 bits wide. A register can be accessed as a whole, or as a single 32-bit half chosen by address bit 2. Command processing does not depend on the enable bit: the sequencer drains whatever lies between the read and write offsets.

Top module: `cmdq_frontend`

## Requirements
- R1: After reset, the control register reads 0x8000_0000 (enable 0, idle flag 1). The base, write offset and read offset registers read 0. `mem_req` and `exe_valid` are low.
- R2: The register offsets are decoded from `acc_addr[4:3]`: 0x00 control (bit 0 enable, bit 31 idle), 0x08 queue base, 0x10 write offset, 0x18 read offset. With `acc_dw`=1 an access covers all 64 bits. With `acc_dw`=0, `acc_addr[2]` selects the upper half, and a read returns that half in bits 31:0 with bits 63:32 at zero.
- R3: A 32-bit write changes only the addressed half of the register and keeps the other half.
- R4: Written base values have bits 51:48 and 15:12 forced to 0. Base writes have no effect while the enable bit is 1. An accepted base write sets the write offset equal to the read offset.
- R5: The ring size is (base bits 7:0 + 1) × 4096 bytes. Only bits 19:5 of a written write offset are kept, and a kept value at or above the ring size leaves the write offset unchanged.
- R6: While the read offset differs from the write offset, the block raises `mem_req` with address (base bits 47:12 × 4096) + read offset. It holds the request until `mem_rsp_valid`, with one fetch outstanding at a time.
- R7: A successful fetch drives `exe_valid` with the returned 256-bit data on `exe_cmd`. Both are held until `exe_done`, and no new fetch starts before then.
- R8: The read offset grows by 32 per command and returns to 0 when it reaches the ring size.
- R9: A fetch answered with `mem_rsp_err` is not passed to the executor, but the read offset still advances.
- R10: The idle flag (control bit 31) reads 1 exactly when the read offset equals the write offset.
- R11: Writes to the read offset register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_dw | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| acc_addr | input | 5 | Byte offset within the register window |
| acc_wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| acc_rdata | output | 64 | Read data for the addressed register (combinational) |
| mem_req | output | 1 | Command fetch request |
| mem_addr | output | PA_W | Fetch byte address |
| mem_rsp_valid | input | 1 | Fetch response strobe |
| mem_rsp_err | input | 1 | Fetch failed |
| mem_rsp_data | input | CMD_BYTES*8 | Fetched command |
| exe_valid | output | 1 | Command offered to the executor |
| exe_cmd | output | CMD_BYTES*8 | Command contents |
| exe_done | input | 1 | Executor finished the offered command |

## Verification
The bench keeps the default parameters: a 48-bit address, 32-byte commands and an 8-bit page-count field. It programs a page count of 3, which gives a ring of 512 commands. With that size, one base rewrite made during a stalled command sends the sequencer around the whole ring, through the wrap point and back. This covers the wrap, the error skip on a repeated offset, and the write-offset reset within a few thousand cycles. The memory and executor models answer with different latencies, so both handshakes are held for several cycles.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_EXEC  = 2'd2
  } sq_state_e;

  localparam logic [1:0] RSEL_CTRL = 2'd0;
  localparam logic [1:0] RSEL_BASE = 2'd1;
  localparam logic [1:0] RSEL_WPTR = 2'd2;
  localparam logic [1:0] RSEL_RPTR = 2'd3;
endpackage

// File: rtl/cmdq_ring_math.sv
module cmdq_ring_math #(
  parameter int PAGES_W  = 8,
  parameter int SZ_SHIFT = 7,
  parameter int IDX_W    = 15,
  parameter int SZ_W     = 16
) (
  input  logic [PAGES_W-1:0] pages,
  input  logic [IDX_W-1:0]   cur_idx,
  output logic [SZ_W-1:0]    ring_units,
  output logic [IDX_W-1:0]   next_idx
);
  logic [SZ_W-1:0]  page_cnt;
  logic [IDX_W:0]   inc;

  always_comb begin
    page_cnt   = SZ_W'(pages) + SZ_W'(1);
    ring_units = page_cnt << SZ_SHIFT;
    inc        = {1'b0, cur_idx} + {{IDX_W{1'b0}}, 1'b1};
    if (SZ_W'(inc) >= ring_units) next_idx = '0;
    else                          next_idx = inc[IDX_W-1:0];
  end
endmodule

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int IDX_W     = 15,
  parameter int CMD_SHIFT = 5,
  parameter int SZ_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_dw,
  input  logic [4:0]       acc_addr,
  input  logic [63:0]      acc_wdata,
  output logic [63:0]      acc_rdata,
  input  logic [IDX_W-1:0] rptr_idx,
  input  logic [SZ_W-1:0]  ring_units,
  output logic             enable_q,
  output logic [63:0]      base_q,
  output logic [IDX_W-1:0] wptr_idx
);
  localparam int OFS_MSB = IDX_W + CMD_SHIFT - 1;
  localparam logic [63:0] BASE_KEEP = ~((64'hF << 48) | (64'hF << 12));

  logic [1:0]       sel;
  logic             wr;
  logic             hi_only;
  logic [63:0]      cur64;
  logic [63:0]      merged;
  logic [IDX_W-1:0] wptr_cand;
  logic             in_range;
  logic             ctrl_we, base_we, wptr_we;
  logic             enable_d;
  logic [63:0]      base_d;
  logic [IDX_W-1:0] wptr_d;
  logic             idle_flag;
  logic             unused_addr;

  assign unused_addr = ^acc_addr[1:0];
  assign sel       = acc_addr[4:3];
  assign wr        = acc_valid & acc_write;
  assign hi_only   = ~acc_dw & acc_addr[2];
  assign idle_flag = (rptr_idx == wptr_idx);

  always_comb begin
    case (sel)
      RSEL_CTRL: cur64 = {32'd0, idle_flag, 30'd0, enable_q};
      RSEL_BASE: cur64 = base_q;
      RSEL_WPTR: cur64 = 64'({wptr_idx, {CMD_SHIFT{1'b0}}});
      default:   cur64 = 64'({rptr_idx, {CMD_SHIFT{1'b0}}});
    endcase
  end

  always_comb begin
    if (acc_dw)            merged = acc_wdata;
    else if (acc_addr[2])  merged = {acc_wdata[31:0], cur64[31:0]};
    else                   merged = {cur64[63:32], acc_wdata[31:0]};
    wptr_cand = merged[OFS_MSB:CMD_SHIFT];
    in_range  = (SZ_W'(wptr_cand) < ring_units);
    ctrl_we   = wr && (sel == RSEL_CTRL) && !hi_only;
    base_we   = wr && (sel == RSEL_BASE) && !enable_q;
    wptr_we   = (wr && (sel == RSEL_WPTR) && in_range) || base_we;
    enable_d  = merged[0];
    base_d    = merged & BASE_KEEP;
    wptr_d    = base_we ? rptr_idx : wptr_cand;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      base_q   <= '0;
      wptr_idx <= '0;
    end else begin
      if (ctrl_we) enable_q <= enable_d;
      if (base_we) base_q   <= base_d;
      if (wptr_we) wptr_idx <= wptr_d;
    end
  end

  always_comb begin
    if (acc_dw)           acc_rdata = cur64;
    else if (acc_addr[2]) acc_rdata = {32'd0, cur64[63:32]};
    else                  acc_rdata = {32'd0, cur64[31:0]};
  end

  assert_base_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == RSEL_BASE && enable_q) |=> $stable(base_q));

  assert_base_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q[51:48] == 4'h0 && base_q[15:12] == 4'h0));

  assert_wptr_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr_idx != $past(wptr_idx)) |->
      $past(wr && (sel == RSEL_WPTR || sel == RSEL_BASE)));
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_pkg::*;
#(
  parameter int PA_W       = 48,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 15,
  parameter int CMD_SHIFT  = 5,
  parameter int CMD_W      = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PA_W-1:PAGE_SHIFT]   base_addr,
  input  logic [IDX_W-1:0]           wptr_idx,
  input  logic [IDX_W-1:0]           next_idx,
  output logic [IDX_W-1:0]           rptr_idx,
  output logic                       mem_req,
  output logic [PA_W-1:0]            mem_addr,
  input  logic                       mem_rsp_valid,
  input  logic                       mem_rsp_err,
  input  logic [CMD_W-1:0]           mem_rsp_data,
  output logic                       exe_valid,
  output logic [CMD_W-1:0]           exe_cmd,
  input  logic                       exe_done
);
  sq_state_e        state_q, state_d;
  logic [IDX_W-1:0] rptr_q;
  logic             rptr_we;
  logic [CMD_W-1:0] cmd_q;
  logic             cmd_we;

  always_comb begin
    state_d = state_q;
    rptr_we = 1'b0;
    cmd_we  = 1'b0;
    case (state_q)
      SQ_IDLE:  if (rptr_q != wptr_idx) state_d = SQ_FETCH;
      SQ_FETCH: if (mem_rsp_valid) begin
                  if (mem_rsp_err) begin
                    rptr_we = 1'b1;
                    state_d = SQ_IDLE;
                  end else begin
                    cmd_we  = 1'b1;
                    state_d = SQ_EXEC;
                  end
                end
      SQ_EXEC:  if (exe_done) begin
                  rptr_we = 1'b1;
                  state_d = SQ_IDLE;
                end
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      rptr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (rptr_we) rptr_q <= next_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd_we) cmd_q <= mem_rsp_data;
  end

  assign rptr_idx  = rptr_q;
  assign mem_req   = (state_q == SQ_FETCH);
  assign mem_addr  = {base_addr, {PAGE_SHIFT{1'b0}}} + PA_W'({rptr_q, {CMD_SHIFT{1'b0}}});
  assign exe_valid = (state_q == SQ_EXEC);
  assign exe_cmd   = cmd_q;

  assert_fetch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(rptr_q)));

  assert_exec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid && !exe_done) |=> (exe_valid && $stable(exe_cmd)));

  assert_one_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rptr_q != $past(rptr_q)) |->
      (rptr_q == IDX_W'($past(rptr_q) + 1'b1) || rptr_q == '0));

  assert_err_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rsp_valid && mem_rsp_err) |=> !exe_valid);

  assert_idle_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && rptr_q == wptr_idx) |=> !mem_req);
endmodule

// File: rtl/cmdq_frontend.sv
module cmdq_frontend #(
  parameter int PA_W       = 48,
  parameter int CMD_BYTES  = 32,
  parameter int PAGES_W    = 8,
  parameter int PAGE_SHIFT = 12,
  parameter int OFS_MSB    = 19
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_valid,
  input  logic                   acc_write,
  input  logic                   acc_dw,
  input  logic [4:0]             acc_addr,
  input  logic [63:0]            acc_wdata,
  output logic [63:0]            acc_rdata,
  output logic                   mem_req,
  output logic [PA_W-1:0]        mem_addr,
  input  logic                   mem_rsp_valid,
  input  logic                   mem_rsp_err,
  input  logic [CMD_BYTES*8-1:0] mem_rsp_data,
  output logic                   exe_valid,
  output logic [CMD_BYTES*8-1:0] exe_cmd,
  input  logic                   exe_done
);
  localparam int CMD_W     = CMD_BYTES * 8;
  localparam int CMD_SHIFT = $clog2(CMD_BYTES);
  localparam int IDX_W     = OFS_MSB - CMD_SHIFT + 1;
  localparam int SZ_SHIFT  = PAGE_SHIFT - CMD_SHIFT;
  localparam int SZ_W      = PAGES_W + 1 + SZ_SHIFT;

  logic             enable_q;
  logic [63:0]      base_q;
  logic [IDX_W-1:0] wptr_idx;
  logic [IDX_W-1:0] rptr_idx;
  logic [IDX_W-1:0] next_idx;
  logic [SZ_W-1:0]  ring_units;
  logic             unused_enable;

  assign unused_enable = enable_q;

  cmdq_ring_math #(
    .PAGES_W (PAGES_W),
    .SZ_SHIFT(SZ_SHIFT),
    .IDX_W   (IDX_W),
    .SZ_W    (SZ_W)
  ) u_math (
    .pages     (base_q[PAGES_W-1:0]),
    .cur_idx   (rptr_idx),
    .ring_units(ring_units),
    .next_idx  (next_idx)
  );

  cmdq_regs #(
    .IDX_W    (IDX_W),
    .CMD_SHIFT(CMD_SHIFT),
    .SZ_W     (SZ_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_dw    (acc_dw),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .rptr_idx  (rptr_idx),
    .ring_units(ring_units),
    .enable_q  (enable_q),
    .base_q    (base_q),
    .wptr_idx  (wptr_idx)
  );

  cmdq_seq #(
    .PA_W      (PA_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .IDX_W     (IDX_W),
    .CMD_SHIFT (CMD_SHIFT),
    .CMD_W     (CMD_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .base_addr    (base_q[PA_W-1:PAGE_SHIFT]),
    .wptr_idx     (wptr_idx),
    .next_idx     (next_idx),
    .rptr_idx     (rptr_idx),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err  (mem_rsp_err),
    .mem_rsp_data (mem_rsp_data),
    .exe_valid    (exe_valid),
    .exe_cmd      (exe_cmd),
    .exe_done     (exe_done)
  );
endmodule

// File: tb/sim_cmdq_frontend.sv
module sim_cmdq_frontend;
  localparam int RING = 16384;
  localparam logic [47:0] BASE_PA = 48'h0012_ABCD_0000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         acc_valid, acc_write, acc_dw;
  logic [4:0]   acc_addr;
  logic [63:0]  acc_wdata, acc_rdata;
  logic         mem_req;
  logic [47:0]  mem_addr;
  logic         mem_rsp_valid, mem_rsp_err;
  logic [255:0] mem_rsp_data;
  logic         exe_valid;
  logic [255:0] exe_cmd;
  logic         exe_done;

  int total = 0;
  int bad = 0;
  int fetches = 0;
  int mem_lat = 2;
  int exe_lat = 3;
  int mcnt = 0;
  int ecnt = 0;
  bit err_on = 0;
  int err_ofs = 0;
  logic [255:0] exp_q[$];

  always #10 clk = ~clk;

  cmdq_frontend u0 (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_dw(acc_dw),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .exe_valid(exe_valid), .exe_cmd(exe_cmd), .exe_done(exe_done)
  );

  function automatic logic [255:0] pat(input logic [47:0] a);
    return {4{16'hC0DE, a}};
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: expected commands for offsets [from, to) around the ring
  task automatic push_range(input int from, input int to);
    int o = from;
    while (o != to) begin
      if (!(err_on && o == err_ofs)) exp_q.push_back(pat(BASE_PA + 48'(o)));
      o += 32;
      if (o >= RING) o = 0;
    end
  endtask

  task automatic wr(input logic [4:0] a, input bit dw, input logic [63:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_dw = dw; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd(input logic [4:0] a, input bit dw, output logic [63:0] d);
    acc_valid = 1; acc_write = 0; acc_dw = dw; acc_addr = a;
    #1 d = acc_rdata;
    acc_valid = 0;
  endtask

  task automatic wait_quiet();
    logic [63:0] c;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      rd(5'h00, 1, c);
      if (c[31] && exp_q.size() == 0) break;
    end
  endtask

  // memory model
  always @(negedge clk) begin
    if (mem_rsp_valid) begin
      mem_rsp_valid = 0; mem_rsp_err = 0; mcnt = 0;
    end else if (mem_req) begin
      mcnt++;
      if (mcnt >= mem_lat) begin
        mem_rsp_valid = 1;
        mem_rsp_data  = pat(mem_addr);
        mem_rsp_err   = err_on && (mem_addr == BASE_PA + 48'(err_ofs));
        fetches++;
      end
    end
  end

  // executor model and scoreboard monitor
  always @(negedge clk) begin
    if (exe_done) begin
      exe_done = 0; ecnt = 0;
    end else if (exe_valid) begin
      ecnt++;
      if (ecnt >= exe_lat) begin
        exe_done = 1;
        if (exp_q.size() == 0) chk("R7 unexpected command", exe_cmd, '0);
        else chk("R6/R7 command data", exe_cmd, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    rst_n = 0; acc_valid = 0; acc_write = 0; acc_dw = 1; acc_addr = '0; acc_wdata = '0;
    mem_rsp_valid = 0; mem_rsp_err = 0; mem_rsp_data = '0; exe_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(5'h00, 1, v); chk("R1 ctrl reset", 256'(v), 256'h8000_0000);
    rd(5'h08, 1, v); chk("R1 base reset", 256'(v), 0);
    rd(5'h10, 1, v); chk("R1 wptr reset", 256'(v), 0);
    rd(5'h18, 1, v); chk("R1 rptr reset", 256'(v), 0);
    chk("R1 no activity", 256'({mem_req, exe_valid}), 0);

    wr(5'h08, 1, 64'h000F_0000_ABCD_F003);
    rd(5'h08, 1, v); chk("R4 base masked", 256'(v), 256'h0000_0000_ABCD_0003);
    wr(5'h0C, 0, 64'h0000_0012);
    rd(5'h08, 1, v); chk("R3 upper half write", 256'(v), 256'h0000_0012_ABCD_0003);
    rd(5'h0C, 0, v); chk("R2 32-bit upper read", 256'(v), 256'h12);
    rd(5'h08, 0, v); chk("R2 32-bit lower read", 256'(v), 256'hABCD_0003);

    wr(5'h10, 1, 64'(RING));
    rd(5'h10, 1, v); chk("R5 out of range ignored", 256'(v), 0);

    err_on = 1; err_ofs = 32'h20;
    push_range(0, 32'h60);
    wr(5'h10, 1, 64'h0000_0000_0010_007F);
    rd(5'h10, 1, v); chk("R5 bits 19:5 kept", 256'(v), 256'h60);
    rd(5'h00, 1, v); chk("R10 busy flag", 256'(v[31]), 0);
    wait_quiet();
    rd(5'h18, 1, v); chk("R8 rptr advanced", 256'(v), 256'h60);
    chk("R9 failed fetch counted", 256'(fetches), 3);
    rd(5'h00, 1, v); chk("R10 idle flag", 256'(v[31]), 1);

    wr(5'h00, 1, 64'h1);
    rd(5'h00, 1, v); chk("R2 enable readback", 256'(v), 256'h8000_0001);
    wr(5'h08, 1, 64'h55);
    rd(5'h08, 1, v); chk("R4 locked base", 256'(v), 256'h0000_0012_ABCD_0003);
    wr(5'h00, 0, 64'h0);

    wr(5'h18, 1, 64'h100);
    rd(5'h18, 1, v); chk("R11 rptr read only", 256'(v), 256'h60);
    chk("R11 no fetch", 256'(mem_req), 0);

    exe_lat = 40;
    push_range(32'h60, 32'hC0);
    wr(5'h10, 1, 64'hC0);
    repeat (12) @(negedge clk);
    chk("R7 executor stalled", 256'(exe_valid), 1);
    wr(5'h08, 1, 64'h0000_0012_ABCD_0003);
    rd(5'h10, 1, v); chk("R4 wptr set to rptr", 256'(v), 256'h60);
    exe_lat = 1;
    push_range(32'hC0, 32'h60);
    wait_quiet();
    rd(5'h18, 1, v); chk("R8 full wrap", 256'(v), 256'h60);
    chk("R7 queue drained", 256'(exp_q.size()), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule